// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Line-Break Detector

This block receives asynchronous serial characters on a single input line. It works from an enable tick at sixteen times the bit rate, which a baud generator elsewhere supplies. A falling edge on the idle-high line starts a character. The block checks the start bit again in the middle of the bit, then samples every data bit at its centre, and then samples the stop bit. A character carries eight data bits, least significant bit first, and may carry a ninth bit. Software reads the received byte, the ninth bit and the completion flag through a small register port with three addresses.

A bad stop bit sets an error flag in the status register. The most significant bit of the control register is shared. Depending on a select bit, it reads either this error flag or a plain mode bit that software stores.

A separate counter watches for a line held low far longer than any character. When the line has been low for eleven bit times, the block pulses an output for one clock. System logic can use that pulse as a reset request that forces the chip into its programming mode. The block also keeps a sticky flag that software reads.

Top module: `uart_brk_rx`

## Requirements
- R1: After reset all three registers (control at address 0, status at address 1, data at address 2) read 0, and `rx_irq` and `break_pulse` are low.
- R2: An 8-bit character is shifted in least significant bit first. At the stop-bit sample its byte appears at address 2 and the receive-complete flag (control bit 0) sets. `rx_irq` follows that flag.
- R3: When control bit 6 is 1, frames carry a ninth bit after the data, and that bit is readable at control bit 2. In 8-bit frames control bit 2 reads 0.
- R4: A low pulse on the line that has ended before the middle of the start bit is discarded: no flag sets and the data register keeps its value.
- R5: A stop bit sampled low sets the framing-error flag (status bit 0). The receive-complete flag still sets. The receiver then waits for the line to return high before it looks for a new start bit.
- R6: When status bit 7 is 1, control bit 7 reads the framing-error flag. When status bit 7 is 0, control bit 7 reads back the last value written to it.
- R7: The framing-error flag holds until software clears it. Writing 0 to status bit 0 clears it, and so does writing 0 to control bit 7 while status bit 7 is 1.
- R8: The receive-complete flag holds until a write of 0 to control bit 0 clears it.
- R9: A line sampled low on 176 consecutive ticks (11 bit times) produces exactly one single-clock `break_pulse` and sets the sticky break flag (status bit 1). Writing 1 to status bit 1 clears the flag.
- R10: Any high sample resets the low-time count, so two low stretches of 10 bit times with a high bit time between them produce no break.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| os_tick | input | 1 | One-clock enable at 16x the bit rate |
| rxd | input | 1 | Serial receive line, idle high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address (0 control, 1 status, 2 data) |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 8 | Read data for `rd_addr`, combinational |
| rx_irq | output | 1 | Receive-complete flag level |
| break_pulse | output | 1 | One-clock pulse when a break is detected |

## Verification
The hardest cases to reach from the ports are the ones where a long low line must be told apart from a break. A held-low line also looks like a character with a bad stop bit. So the stimulus for every break test expects a zero byte with a framing error as well as the break result.

Two situations are driven in sequence. The first holds the line low for twelve bit times, which is past the eleven-bit limit. The second holds it low for ten bit times, sends one high bit, then holds it low for ten more. Counting pulses at the port separates a missing count reset from a correct one, and it also catches a pulse that lasts more than one clock.

// File: rtl/uart_brk_pkg.sv
package uart_brk_pkg;

    localparam int DATA_W = 8;

    localparam logic [1:0] ADDR_CTL  = 2'd0;
    localparam logic [1:0] ADDR_STAT = 2'd1;
    localparam logic [1:0] ADDR_DATA = 2'd2;

    // control register bit positions
    localparam int CTL_TOP  = 7;
    localparam int CTL_NINE = 6;
    localparam int CTL_RB8  = 2;
    localparam int CTL_RI   = 0;

    // status register bit positions
    localparam int STAT_SEL = 7;
    localparam int STAT_BRK = 1;
    localparam int STAT_FE  = 0;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_STOP,
        RX_HOLD
    } rx_state_t;

    typedef struct packed {
        logic              mode0;
        logic              nine;
        logic              fe_sel;
        logic              fe;
        logic              brk;
        logic              ri;
        logic              rb8;
        logic [DATA_W-1:0] rdata;
    } regs_t;

endpackage

// File: rtl/uart_brk_sync.sv
module uart_brk_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-2:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '1;
        else        sh_q <= sh_d;
    end

    assign dout = sh_q[STAGES-1];
endmodule

// File: rtl/uart_brk_frame.sv
module uart_brk_frame
    import uart_brk_pkg::*;
#(
    parameter int OVS = 16,
    parameter int DW  = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          line,
    input  logic          nine,
    output logic          done,
    output logic          stop_bad,
    output logic [DW-1:0] data,
    output logic          bit8
);
    localparam int CW   = $clog2(OVS);
    localparam int IW   = $clog2(DW + 2);
    localparam int HALF = OVS / 2;

    typedef struct packed {
        rx_state_t     st;
        logic [CW-1:0] cnt;
        logic [IW-1:0] idx;
        logic [DW:0]   shreg;
        logic          done;
        logic          stop_bad;
        logic [DW-1:0] data;
        logic          bit8;
    } frame_t;

    frame_t r_d, r_q;
    logic [IW-1:0] last_idx;

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        last_idx = nine ? IW'(DW) : IW'(DW - 1);
        if (tick) begin
            unique case (r_q.st)
                RX_IDLE: begin
                    if (!line) begin
                        r_d.st  = RX_START;
                        r_d.cnt = '0;
                    end
                end
                RX_START: begin
                    if (r_q.cnt == CW'(HALF - 1)) begin
                        r_d.cnt = '0;
                        r_d.idx = '0;
                        r_d.st  = line ? RX_IDLE : RX_DATA;
                    end else begin
                        r_d.cnt = r_q.cnt + 1'b1;
                    end
                end
                RX_DATA: begin
                    if (r_q.cnt == CW'(OVS - 1)) begin
                        r_d.cnt              = '0;
                        r_d.shreg[r_q.idx]   = line;
                        r_d.idx              = r_q.idx + 1'b1;
                        if (r_q.idx == last_idx) r_d.st = RX_STOP;
                    end else begin
                        r_d.cnt = r_q.cnt + 1'b1;
                    end
                end
                RX_STOP: begin
                    if (r_q.cnt == CW'(OVS - 1)) begin
                        r_d.cnt      = '0;
                        r_d.done     = 1'b1;
                        r_d.stop_bad = !line;
                        r_d.data     = r_q.shreg[DW-1:0];
                        r_d.bit8     = nine ? r_q.shreg[DW] : 1'b0;
                        r_d.st       = line ? RX_IDLE : RX_HOLD;
                    end else begin
                        r_d.cnt = r_q.cnt + 1'b1;
                    end
                end
                RX_HOLD: begin
                    if (line) r_d.st = RX_IDLE;
                end
                default: r_d.st = RX_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= RX_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign done     = r_q.done;
    assign stop_bad = r_q.stop_bad;
    assign data     = r_q.data;
    assign bit8     = r_q.bit8;
endmodule

// File: rtl/uart_brk_detect.sv
module uart_brk_detect #(
    parameter int OVS        = 16,
    parameter int BREAK_BITS = 11
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic line,
    output logic pulse
);
    localparam int LIMIT = BREAK_BITS * OVS;
    localparam int CW    = $clog2(LIMIT + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          pulse;
    } det_t;

    det_t r_d, r_q;

    always_comb begin
        r_d       = r_q;
        r_d.pulse = 1'b0;
        if (tick) begin
            if (line) begin
                r_d.cnt = '0;
            end else if (r_q.cnt != CW'(LIMIT)) begin
                r_d.cnt = r_q.cnt + 1'b1;
                if (r_q.cnt == CW'(LIMIT - 1)) r_d.pulse = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign pulse = r_q.pulse;
endmodule

// File: rtl/uart_brk_rx.sv
module uart_brk_rx
    import uart_brk_pkg::*;
#(
    parameter int OVS         = 16,
    parameter int BREAK_BITS  = 11,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       os_tick,
    input  logic       rxd,
    input  logic       wr_en,
    input  logic [1:0] wr_addr,
    input  logic [7:0] wr_data,
    input  logic [1:0] rd_addr,
    output logic [7:0] rd_data,
    output logic       rx_irq,
    output logic       break_pulse
);
    logic              line_s;
    logic              rx_done;
    logic              rx_stop_bad;
    logic [DATA_W-1:0] rx_byte;
    logic              rx_bit8;
    logic              brk_hit;
    regs_t             r_d, r_q;

    uart_brk_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (rxd),
        .dout (line_s)
    );

    uart_brk_frame #(.OVS(OVS), .DW(DATA_W)) u_frame (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (os_tick),
        .line    (line_s),
        .nine    (r_q.nine),
        .done    (rx_done),
        .stop_bad(rx_stop_bad),
        .data    (rx_byte),
        .bit8    (rx_bit8)
    );

    uart_brk_detect #(.OVS(OVS), .BREAK_BITS(BREAK_BITS)) u_det (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (os_tick),
        .line (line_s),
        .pulse(brk_hit)
    );

    always_comb begin
        r_d = r_q;
        if (wr_en) begin
            unique case (wr_addr)
                ADDR_CTL: begin
                    r_d.nine = wr_data[CTL_NINE];
                    if (!r_q.fe_sel)              r_d.mode0 = wr_data[CTL_TOP];
                    else if (!wr_data[CTL_TOP])   r_d.fe    = 1'b0;
                    if (!wr_data[CTL_RI])         r_d.ri    = 1'b0;
                end
                ADDR_STAT: begin
                    r_d.fe_sel = wr_data[STAT_SEL];
                    if (!wr_data[STAT_FE])        r_d.fe    = 1'b0;
                    if (wr_data[STAT_BRK])        r_d.brk   = 1'b0;
                end
                default: ;
            endcase
        end
        if (rx_done) begin
            r_d.ri    = 1'b1;
            r_d.rdata = rx_byte;
            r_d.rb8   = rx_bit8;
            if (rx_stop_bad) r_d.fe = 1'b1;
        end
        if (brk_hit) r_d.brk = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        rd_data = '0;
        unique case (rd_addr)
            ADDR_CTL: begin
                rd_data[CTL_TOP]  = r_q.fe_sel ? r_q.fe : r_q.mode0;
                rd_data[CTL_NINE] = r_q.nine;
                rd_data[CTL_RB8]  = r_q.rb8;
                rd_data[CTL_RI]   = r_q.ri;
            end
            ADDR_STAT: begin
                rd_data[STAT_SEL] = r_q.fe_sel;
                rd_data[STAT_BRK] = r_q.brk;
                rd_data[STAT_FE]  = r_q.fe;
            end
            ADDR_DATA: rd_data = r_q.rdata;
            default:   rd_data = '0;
        endcase
    end

    assign rx_irq      = r_q.ri;
    assign break_pulse = brk_hit;
endmodule

// File: rtl/uart_brk_rx_chk.sv
module uart_brk_rx_chk (
    input logic clk,
    input logic rst_n,
    input logic wr_en,
    input logic line,
    input logic frame_done,
    input logic stop_bad,
    input logic fe,
    input logic ri,
    input logic brk,
    input logic break_pulse
);
    assert_done_sets_ri_R2: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> ri);

    assert_bad_stop_sets_fe_R5: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done && stop_bad |=> fe);

    assert_fe_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fe && !wr_en |=> fe);

    assert_ri_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ri && !wr_en |=> ri);

    assert_pulse_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        break_pulse |=> !break_pulse);

    assert_pulse_sets_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        break_pulse |=> brk);

    assert_pulse_after_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
        break_pulse |-> $past(!line));
endmodule

bind uart_brk_rx uart_brk_rx_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .line       (line_s),
    .frame_done (rx_done),
    .stop_bad   (rx_stop_bad),
    .fe         (r_q.fe),
    .ri         (r_q.ri),
    .brk        (r_q.brk),
    .break_pulse(break_pulse)
);

// File: tb/uart_brk_rx_tb.sv
module uart_brk_rx_tb;
    localparam int BIT_CLK = 64;  // 16 ticks, one tick every 4 clocks

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       os_tick = 1'b0;
    logic       rxd = 1'b1;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [1:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       rx_irq;
    logic       break_pulse;

    typedef struct {
        logic [7:0] d;
        logic       b8;
        logic       fe;
    } exp_t;

    exp_t q[$];
    int   n_checks = 0;
    int   n_errors = 0;
    int   pulses   = 0;
    bit   mon_busy = 1'b0;
    bit   reported = 1'b0;
    logic mode0 = 1'b0;
    logic nine  = 1'b0;
    logic sel   = 1'b0;
    logic [1:0] tdiv = '0;

    uart_brk_rx u_dut (
        .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rxd(rxd),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .rx_irq(rx_irq), .break_pulse(break_pulse)
    );

    always #4 clk = ~clk;

    always @(posedge clk) begin
        tdiv    <= tdiv + 2'd1;
        os_tick <= (tdiv == 2'd3);
    end

    always @(negedge clk) if (break_pulse) pulses++;

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        if (!reported) begin
            reported = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        end
        $finish;
    endtask

    task automatic reg_wr(input logic [1:0] a, input logic [7:0] v);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic reg_rd(input logic [1:0] a, output logic [7:0] v);
        @(negedge clk);
        rd_addr = a;
        #1 v = rd_data;
    endtask

    task automatic hold(input logic v, input int bits);
        rxd = v;
        repeat (bits * BIT_CLK) @(negedge clk);
    endtask

    task automatic send_frame(input logic [7:0] d, input logic b8, input logic stopv);
        exp_t e;
        e.d = d; e.b8 = nine ? b8 : 1'b0; e.fe = !stopv;
        q.push_back(e);
        hold(1'b0, 1);
        for (int i = 0; i < 8; i++) hold(d[i], 1);
        if (nine) hold(b8, 1);
        hold(stopv, 1);
        rxd = 1'b1;
        repeat (16) @(negedge clk);
        if (!stopv) hold(1'b1, 1);
    endtask

    task automatic drain();
        while (q.size() != 0 || mon_busy) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    // monitor: pops the expected item on each completed character
    initial begin
        exp_t e;
        logic [7:0] v;
        forever begin
            @(negedge clk);
            if (rx_irq) begin
                mon_busy = 1'b1;
                if (q.size() == 0) begin
                    check("R4", "unexpected character", 1, 0);
                end else begin
                    e = q.pop_front();
                    reg_rd(2'd2, v);
                    check("R2", "data byte", v, e.d);
                    reg_rd(2'd0, v);
                    check("R2", "complete flag", v[0], 1'b1);
                    check("R3", "ninth bit", v[2], e.b8);
                    check("R6", "control top bit", v[7], sel ? e.fe : mode0);
                    reg_rd(2'd1, v);
                    check("R5", "framing error", v[0], e.fe);
                end
                reg_wr(2'd0, {sel ? 1'b0 : mode0, nine, 6'b0});
                reg_wr(2'd1, {sel, 7'b0});
                reg_rd(2'd1, v);
                check("R7", "framing error cleared", v[0], 1'b0);
                check("R8", "irq cleared", rx_irq, 1'b0);
                mon_busy = 1'b0;
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_errors++;
        n_checks++;
        $display("FAIL watchdog (all requirements): actual=running expected=finished");
        summary();
    end

    initial begin
        logic [7:0] v;
        int p0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        reg_rd(2'd0, v); check("R1", "control after reset", v, 8'h00);
        reg_rd(2'd1, v); check("R1", "status after reset", v, 8'h00);
        reg_rd(2'd2, v); check("R1", "data after reset", v, 8'h00);
        check("R1", "irq after reset", rx_irq, 1'b0);
        check("R1", "pulse after reset", break_pulse, 1'b0);

        // R2: plain 8-bit characters
        send_frame(8'hA5, 1'b0, 1'b1);
        send_frame(8'h3C, 1'b0, 1'b1);
        send_frame(8'h00, 1'b0, 1'b1);
        send_frame(8'hFF, 1'b0, 1'b1);
        drain();

        // R6: stored mode bit reads back when select is 0
        mode0 = 1'b1;
        reg_wr(2'd0, 8'h80);
        reg_rd(2'd0, v); check("R6", "stored mode bit", v[7], 1'b1);
        send_frame(8'h5A, 1'b0, 1'b1);
        drain();

        // R3: nine-bit characters
        nine = 1'b1;
        reg_wr(2'd0, {mode0, 1'b1, 6'b0});
        send_frame(8'h81, 1'b1, 1'b1);
        send_frame(8'h7E, 1'b0, 1'b1);
        drain();
        nine = 1'b0;
        reg_wr(2'd0, {mode0, 1'b0, 6'b0});

        // R5/R6/R7: bad stop with select 0, then select 1
        send_frame(8'h12, 1'b0, 1'b0);
        drain();
        sel = 1'b1;
        reg_wr(2'd1, 8'h80);
        send_frame(8'h34, 1'b0, 1'b0);
        send_frame(8'h56, 1'b0, 1'b1);
        drain();

        // R4: short low glitch is discarded
        rxd = 1'b0;
        repeat (16) @(negedge clk);
        rxd = 1'b1;
        repeat (2000) @(negedge clk);
        check("R4", "irq after glitch", rx_irq, 1'b0);
        reg_rd(2'd2, v); check("R4", "data kept after glitch", v, 8'h56);

        // R9: break of 12 bit times
        p0 = pulses;
        begin
            exp_t e;
            e.d = 8'h00; e.b8 = 1'b0; e.fe = 1'b1;
            q.push_back(e);
        end
        hold(1'b0, 12);
        hold(1'b1, 2);
        check("R9", "break pulse count", pulses - p0, 1);
        drain();
        reg_rd(2'd1, v); check("R9", "break flag sticky", v[1], 1'b1);
        reg_wr(2'd1, {sel, 5'b0, 1'b1, 1'b0});
        reg_rd(2'd1, v); check("R9", "break flag cleared", v[1], 1'b0);

        // R10: high bit between two 10-bit-time lows
        p0 = pulses;
        begin
            exp_t e;
            e.d = 8'h00; e.b8 = 1'b0; e.fe = 1'b1;
            q.push_back(e);
            q.push_back(e);
        end
        hold(1'b0, 10);
        hold(1'b1, 1);
        hold(1'b0, 10);
        hold(1'b1, 2);
        drain();
        check("R10", "no break pulse", pulses - p0, 0);
        reg_rd(2'd1, v); check("R10", "no break flag", v[1], 1'b0);

        summary();
    end
endmodule